// File: doc/BRIEF.md
# Credit-Based Flit Link Transmitter

This block drives the outgoing half of a full-duplex point-to-point link between network-on-chip nodes. A local source hands it packets one 32-bit word at a time over a valid/ready handshake. The first word of each packet is the header, and a marker on the last word closes it. The block turns every word into a 36-bit flit by adding a 3-bit type code and an even-parity bit. After the last word it adds a trailer flit of its own. The trailer carries the XOR of the packet's payload words and is flagged on a separate end-of-packet line.

Flits leave only when the sender holds a credit. A credit stands for one free slot in the receiver's input buffer. The credit count starts at the buffer depth, goes down by one for every flit sent and goes up by one for every pulse on the return wire. The source therefore never overruns the far buffer. The link belongs to one packet from its header until its trailer has been sent. The next packet's header is held off until then.

Top module: `flit_link_tx`

## Requirements
- R1: After reset, linkValid and linkEop are low and inReady is high (the credit count is full).
- R2: A flit carries the word in bits 31:0 and a one-hot type in bits 34:32: 3'b001 for the header (first word of a packet), 3'b010 for a payload word, and 3'b100 for the trailer.
- R3: Bit 35 of every flit is even parity over bits 34:0, so the XOR of all 36 bits is zero.
- R4: A word accepted on a clock edge (inValid and inReady both high) appears on linkFlit with linkValid high right after that edge. linkValid is high for exactly one cycle per flit.
- R5: The credit count starts at BUF_DEPTH. No more than BUF_DEPTH flits are ever outstanding, and inReady is low whenever the count is zero.
- R6: Each cycle with creditRet high restores one credit. A flit sent in the same cycle as a returned credit leaves the count unchanged.
- R7: After the last word of a packet, the block sends one trailer flit with linkEop high. Its data field is the XOR of all payload words and excludes the header. linkEop is high for trailer flits only.
- R8: From the acceptance of a packet's last word until its trailer has been sent, inReady is low. No word of the next packet goes out before that trailer.
- R9: The trailer also consumes a credit and waits until a credit is available.
- R10: A packet may hold any number of payload words, including none. A header-only packet gets a trailer with a zero checksum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Source offers a word |
| inReady | output | 1 | Block takes the offered word on this edge |
| inData | input | 32 | Word from the source |
| inLast | input | 1 | Offered word is the last of its packet |
| linkFlit | output | 36 | Flit on the link: parity, type, data |
| linkValid | output | 1 | Flit on linkFlit is valid this cycle |
| linkEop | output | 1 | End-of-packet line, high with the trailer |
| creditRet | input | 1 | Credit return wire, one pulse per freed slot |

## Verification
Four properties are checked on every cycle. Every flit has even parity and a one-hot type. The end-of-packet line agrees with the trailer type. The number of outstanding flits, rebuilt from the link ports, never exceeds the buffer depth, and inReady is low when that limit is reached. Headers and trailers alternate, so no packet starts inside another. The bench scenarios alone can show that the data and checksum values are right and that a flit appears in the cycle after acceptance. They also show that a credit pulse releases exactly one flit, that a send and a return in the same cycle cancel, and that a finished packet's trailer stalls for lack of credit while the next header waits behind it.

// File: rtl/flit_tx_pkg.sv
package flit_tx_pkg;

  localparam int TYPE_W = 3;

  localparam logic [TYPE_W-1:0] TYPE_HEAD = 3'b001;
  localparam logic [TYPE_W-1:0] TYPE_BODY = 3'b010;
  localparam logic [TYPE_W-1:0] TYPE_TAIL = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BODY,
    ST_TAIL
  } txState_t;

  typedef struct packed {
    logic sendWord;
    logic wordIsHead;
    logic sendTail;
  } txStrobes_t;

endpackage

// File: rtl/flit_tx_ctrl.sv
module flit_tx_ctrl
  import flit_tx_pkg::*;
#(
  parameter int BUF_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       creditRet,
  output logic       inReady,
  output txStrobes_t strobes
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  txState_t         state;
  txState_t         stateNext;
  logic [CNT_W-1:0] creditCnt;
  logic             haveCredit;
  logic             accept;
  logic             spend;

  assign haveCredit = (creditCnt != '0);
  assign inReady    = haveCredit && (state != ST_TAIL);
  assign accept     = inValid && inReady;
  assign spend      = strobes.sendWord || strobes.sendTail;

  always_comb begin
    strobes.sendWord   = accept;
    strobes.wordIsHead = accept && (state == ST_IDLE);
    strobes.sendTail   = (state == ST_TAIL) && haveCredit;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = inLast ? ST_TAIL : ST_BODY;
      ST_BODY: if (accept && inLast) stateNext = ST_TAIL;
      ST_TAIL: if (strobes.sendTail) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      creditCnt <= CNT_W'(BUF_DEPTH);
    end else begin
      state <= stateNext;
      case ({spend, creditRet})
        2'b10:   creditCnt <= creditCnt - CNT_W'(1);
        2'b01:   creditCnt <= creditCnt + CNT_W'(1);
        default: creditCnt <= creditCnt;
      endcase
    end
  end

endmodule

// File: rtl/flit_tx_datapath.sv
module flit_tx_datapath
  import flit_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  txStrobes_t               strobes,
  input  logic [DATA_W-1:0]        inData,
  output logic [DATA_W+TYPE_W:0]   linkFlit,
  output logic                     linkValid,
  output logic                     linkEop
);

  localparam int FLIT_W = DATA_W + TYPE_W + 1;

  logic [DATA_W-1:0] checksum;
  logic [TYPE_W-1:0] curType;
  logic [DATA_W-1:0] curData;
  logic [FLIT_W-1:0] nextFlit;
  logic              emit;

  assign emit = strobes.sendWord || strobes.sendTail;

  always_comb begin
    if (strobes.sendTail) begin
      curType = TYPE_TAIL;
      curData = checksum;
    end else begin
      curType = strobes.wordIsHead ? TYPE_HEAD : TYPE_BODY;
      curData = inData;
    end
    nextFlit = {^{curType, curData}, curType, curData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkFlit  <= '0;
      linkValid <= 1'b0;
      linkEop   <= 1'b0;
      checksum  <= '0;
    end else begin
      linkValid <= emit;
      linkEop   <= strobes.sendTail;
      if (emit) linkFlit <= nextFlit;
      if (strobes.sendTail || strobes.wordIsHead) checksum <= '0;
      else if (strobes.sendWord)                  checksum <= checksum ^ inData;
    end
  end

endmodule

// File: rtl/flit_link_tx.sv
module flit_link_tx
  import flit_tx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [DATA_W-1:0]      inData,
  input  logic                   inLast,
  output logic [DATA_W+TYPE_W:0] linkFlit,
  output logic                   linkValid,
  output logic                   linkEop,
  input  logic                   creditRet
);

  txStrobes_t strobes;

  flit_tx_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .creditRet (creditRet),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  flit_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .linkFlit  (linkFlit),
    .linkValid (linkValid),
    .linkEop   (linkEop)
  );

endmodule

// File: rtl/flit_link_tx_checker.sv
module flit_link_tx_checker
  import flit_tx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inReady,
  input logic [DATA_W+TYPE_W:0] linkFlit,
  input logic                   linkValid,
  input logic                   linkEop,
  input logic                   creditRet
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1) + 1;

  logic [CNT_W-1:0]  pastOut;
  logic [CNT_W-1:0]  outNow;
  logic              inPkt;
  logic [TYPE_W-1:0] flitType;

  assign flitType = linkFlit[DATA_W+TYPE_W-1:DATA_W];
  assign outNow   = pastOut + CNT_W'(linkValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastOut <= '0;
      inPkt   <= 1'b0;
    end else begin
      pastOut <= pastOut + CNT_W'(linkValid) - CNT_W'(creditRet);
      if (linkValid && flitType == TYPE_HEAD) inPkt <= 1'b1;
      else if (linkValid && flitType == TYPE_TAIL) inPkt <= 1'b0;
    end
  end

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> (^linkFlit) == 1'b0);

  assert_type_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> $countones(flitType) == 1);

  assert_eop_is_tail_R7: assert property (@(posedge clk) disable iff (!rstN)
    linkEop |-> (linkValid && flitType == TYPE_TAIL));

  assert_tail_has_eop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && flitType == TYPE_TAIL) |-> linkEop);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    outNow <= CNT_W'(BUF_DEPTH));

  assert_ready_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outNow == CNT_W'(BUF_DEPTH)) |-> !inReady);

  assert_head_outside_pkt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && flitType == TYPE_HEAD) |-> !inPkt);

  assert_rest_inside_pkt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && flitType != TYPE_HEAD) |-> inPkt);

endmodule

bind flit_link_tx flit_link_tx_checker #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .linkFlit  (linkFlit),
  .linkValid (linkValid),
  .linkEop   (linkEop),
  .creditRet (creditRet)
);

// File: tb/flit_link_tx_bench.sv
`timescale 1ns/1ps
module flit_link_tx_bench;

  localparam int DEPTH = 4;
  localparam logic [2:0] T_HEAD = 3'b001;
  localparam logic [2:0] T_BODY = 3'b010;
  localparam logic [2:0] T_TAIL = 3'b100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inLast = 1'b0;
  logic [35:0] linkFlit;
  logic        linkValid;
  logic        linkEop;
  logic        creditRet;
  logic        manualRet = 1'b0;
  logic        autoPulse = 1'b0;
  logic        autoRet = 1'b0;
  logic [1:0]  retPipe = '0;

  int checks = 0;
  int failures = 0;
  logic [35:0] capFlit [64];
  logic        capEop [64];
  int capN = 0;

  assign creditRet = manualRet | autoPulse;

  always #2.5 clk = ~clk;

  flit_link_tx #(.DATA_W(32), .BUF_DEPTH(DEPTH)) u_flit_link_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .linkFlit(linkFlit),
    .linkValid(linkValid), .linkEop(linkEop), .creditRet(creditRet)
  );

  // link monitor and downstream credit-return model
  initial forever begin
    @(negedge clk);
    if (!rstN) begin
      retPipe   <= '0;
      autoPulse <= 1'b0;
    end else begin
      if (linkValid && capN < 64) begin
        capFlit[capN] = linkFlit;
        capEop[capN]  = linkEop;
        capN++;
      end
      retPipe   <= {retPipe[0], linkValid};
      autoPulse <= autoRet && retPipe[1];
    end
  end

  function automatic logic [35:0] mkFlit(logic [2:0] t, logic [31:0] d);
    return {^{t, d}, t, d};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkFlit(int idx, logic [2:0] t, logic [31:0] d, bit eop, string tag);
    logic [35:0] exp;
    exp = mkFlit(t, d);
    check(capFlit[idx] === exp && capEop[idx] === eop, tag,
          {27'd0, capEop[idx], capFlit[idx]}, {27'd0, eop, exp});
  endtask

  task automatic doReset(bit autoOn);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; manualRet = 1'b0;
    autoRet = autoOn;
    repeat (3) @(negedge clk);
    capN = 0;
    rstN = 1'b1;
  endtask

  task automatic pushWord(logic [31:0] d, bit last);
    @(negedge clk);
    inValid = 1'b1; inData = d; inLast = last;
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic dropValid();
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic creditPulses(int n);
    @(negedge clk);
    manualRet = 1'b1;
    repeat (n) @(negedge clk);
    manualRet = 1'b0;
  endtask

  task automatic testReset();
    doReset(1'b1);
    #1;
    check(linkValid === 1'b0, "R1 linkValid after reset", linkValid, 0);
    check(linkEop === 1'b0, "R1 linkEop after reset", linkEop, 0);
    check(inReady === 1'b1, "R1 inReady after reset", inReady, 1);
  endtask

  task automatic testThreePayload();
    logic [31:0] w [4];
    logic [31:0] sum;
    w[0] = 32'hA5A5_0001; w[1] = 32'h1111_0000;
    w[2] = 32'h0000_2222; w[3] = 32'hF0F0_F0F0;
    sum = w[1] ^ w[2] ^ w[3];
    doReset(1'b1);
    for (int i = 0; i < 4; i++) pushWord(w[i], i == 3);
    dropValid();
    repeat (6) @(negedge clk);
    check(capN == 5, "R4 R7 flit count for 3-word packet", capN, 5);
    checkFlit(0, T_HEAD, w[0], 1'b0, "R2 R3 header flit");
    for (int i = 1; i < 4; i++) checkFlit(i, T_BODY, w[i], 1'b0, "R2 R3 payload flit");
    checkFlit(4, T_TAIL, sum, 1'b1, "R7 trailer checksum and eop");
  endtask

  task automatic testHeaderOnly();
    doReset(1'b1);
    pushWord(32'h8000_0003, 1'b1);
    #1;
    check(linkValid === 1'b1 && linkFlit === mkFlit(T_HEAD, 32'h8000_0003),
          "R4 header visible right after accept", linkFlit, mkFlit(T_HEAD, 32'h8000_0003));
    dropValid();
    @(posedge clk); #1;
    check(linkValid === 1'b1 && linkEop === 1'b1 && linkFlit === mkFlit(T_TAIL, 32'h0),
          "R10 zero-payload trailer", linkFlit, mkFlit(T_TAIL, 32'h0));
    @(posedge clk); #1;
    check(linkValid === 1'b0 && linkEop === 1'b0, "R4 single-cycle valid", linkValid, 0);
  endtask

  task automatic testCredits();
    doReset(1'b0);
    @(negedge clk);
    inValid = 1'b1; inData = 32'h0BAD_F00D; inLast = 1'b0;
    repeat (10) @(negedge clk);
    check(capN == DEPTH, "R5 sends stop at buffer depth", capN, DEPTH);
    check(inReady === 1'b0, "R5 inReady low with no credit", inReady, 0);
    creditPulses(1);
    repeat (4) @(negedge clk);
    check(capN == DEPTH + 1, "R6 one pulse frees one flit", capN, DEPTH + 1);
    creditPulses(2);
    repeat (4) @(negedge clk);
    check(capN == DEPTH + 3, "R6 send with return keeps count", capN, DEPTH + 3);
    check(inReady === 1'b0, "R6 credits exhausted again", inReady, 0);
    dropValid();
  endtask

  task automatic testTrailerStall();
    logic [31:0] sum;
    sum = 32'h0000_00FF ^ 32'h1234_5678 ^ 32'hFFFF_0000;
    doReset(1'b0);
    pushWord(32'h4000_0007, 1'b0);
    pushWord(32'h0000_00FF, 1'b0);
    pushWord(32'h1234_5678, 1'b0);
    pushWord(32'hFFFF_0000, 1'b1);
    @(negedge clk);
    inValid = 1'b1; inData = 32'h4000_0009; inLast = 1'b1;
    repeat (5) @(negedge clk);
    check(capN == 4, "R9 trailer held without credit", capN, 4);
    check(inReady === 1'b0, "R8 next header blocked before trailer", inReady, 0);
    creditPulses(1);
    repeat (3) @(negedge clk);
    check(capN == 5, "R9 trailer sent after one credit", capN, 5);
    checkFlit(4, T_TAIL, sum, 1'b1, "R7 stalled trailer checksum");
    creditPulses(1);
    repeat (3) @(negedge clk);
    check(capN == 6, "R8 next header after trailer", capN, 6);
    checkFlit(5, T_HEAD, 32'h4000_0009, 1'b0, "R8 next packet header");
    dropValid();
  endtask

  task automatic testLongPacket();
    logic [31:0] sum;
    logic [31:0] wd;
    sum = '0;
    doReset(1'b1);
    pushWord(32'hC000_0012, 1'b0);
    for (int i = 0; i < 12; i++) begin
      wd = 32'h9E37_79B9 * (i + 1);
      sum = sum ^ wd;
      pushWord(wd, i == 11);
    end
    dropValid();
    repeat (8) @(negedge clk);
    check(capN == 14, "R10 long packet flit count", capN, 14);
    checkFlit(6, T_BODY, 32'h9E37_79B9 * 6, 1'b0, "R10 mid payload flit");
    checkFlit(13, T_TAIL, sum, 1'b1, "R10 long packet checksum");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testThreePayload();
    testHeaderOnly();
    testCredits();
    testTrailerStall();
    testLongPacket();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule